// File: doc/BRIEF.md
# Data Address Translation with Fault Status Capture

This block turns the virtual address of a load or store into a physical address. It uses a page-table lookup result that a separate structure supplies, so it holds no entries and does no refill. It first works out the privilege mode that governs the access. While the program counter marks privileged code, that mode is the alternate mode when the request asks for it and kernel mode otherwise. Outside privileged code it is the current mode. The access then takes one of four paths: physical pass-through, an invalid-address check, a direct-mapped kernel window (superpage), or the looked-up page entry with its per-mode read and write enables and its fault-on-read and fault-on-write bits. The result is a fault class, a physical address and an uncacheable flag.

When an access faults, three software-visible registers are loaded: the faulting address, a packed status word and a formatted address for the page-table walk. They then lock. Later faults leave them untouched until software reads the fault-address register, which it signals with a one-cycle strobe.

The block runs as a small state machine. In ST_IDLE it accepts a request and snapshots every input (transition ACCEPT). ST_EVAL classifies the snapshot, registers the result and loads the fault registers when allowed (transition EVALUATE). ST_DONE presents the response for one cycle and returns to ST_IDLE (transition RETIRE).

Top module: `data_xlate_unit`

## Requirements
- R1: The effective mode (kernel=0, executive=1, supervisor=2, user=3) is `cfg_cur_mode` when `req_pc_priv` is 0. When `req_pc_priv` is 1 it is `cfg_alt_mode` if `req_altmode` is 1, else kernel. Read enable `tlb_rd_en[m]` and write enable `tlb_wr_en[m]` are indexed by the effective mode m.
- R2: With `req_physical` set, the physical address equals the virtual address and no validity, mode or permission check is applied.
- R3: A virtual address whose bits 63..42 are not all equal gives fault class 2 (generic) with flags bad-VA, access-violation and, for stores, write.
- R4: With `cfg_spage_en` set and vaddr[42:41]=2'b10, the access is superpage. If `cfg_cur_mode` is not kernel, it gives fault class 1 (access violation) with flags access-violation and, for stores, write. Otherwise paddr is vaddr[43:0]. If bit 39 or bit 40 of that value is set, bits 43..40 are forced to 1; otherwise bits 43..40 are cleared.
- R5: On a lookup miss (`tlb_hit`=0) the flags are miss and, for stores, write. The fault class is 3 (primary miss) when `req_ptwalk` is set and 4 (nested miss) otherwise.
- R6: A store whose write enable for the effective mode is clear gives class 2 with flags write, access-violation and, if `tlb_fonw`, fault-on-write. A permitted store with `tlb_fonw` gives class 2 with flags write and fault-on-write.
- R7: A load whose read enable for the effective mode is clear gives class 1 with flags access-violation and, if `tlb_fonr`, fault-on-read. A permitted load with `tlb_fonr` gives class 2 with flag fault-on-read only.
- R8: A permitted lookup hit gives class 0 (none) and paddr = {pfn, vaddr[12:0]}.
- R9: A fault-free result with any paddr bit at or above bit 44 set gives class 5 (machine check). A machine check does not load the fault registers.
- R10: `resp_uncached` is 1 exactly when the class is 0 and paddr bit 39 or bit 40 is set.
- R11: When a fault other than a machine check is reported and the registers are unlocked, they load together. `flt_va` takes the virtual address. `flt_stat` takes (opcode<<11)|(ra<<6)|flags, where the flag bits are write=0, access-violation=1, fault-on-read=2, fault-on-write=3, miss=4, bad-VA=5. `flt_vform` takes base | (vaddr[42:13]<<3). These values are visible with the response.
- R12: Loading the fault registers sets `flt_locked`. While locked, the registers hold their values through later faults, and a `va_rd` pulse clears the lock on the next edge.
- R13: A request accepted in ST_IDLE yields `resp_valid` for exactly one cycle, two clock edges later. `req_valid` is ignored while the block is busy (`req_ready`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_physical | input | 1 | Physical-mode access |
| req_altmode | input | 1 | Use the alternate mode when in privileged code |
| req_ptwalk | input | 1 | Access belongs to a page-table walk |
| req_pc_priv | input | 1 | PC bit 0: privileged code running |
| req_vaddr | input | 64 | Virtual address |
| req_opcode | input | 6 | Opcode recorded on a fault |
| req_ra | input | 5 | Register number recorded on a fault |
| cfg_cur_mode | input | 2 | Current-mode register |
| cfg_alt_mode | input | 2 | Alternate-mode register |
| cfg_spage_en | input | 1 | Superpage window enable |
| cfg_vform_base | input | 64 | Page-table base for the formatted address |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_pfn | input | 31 | Page frame number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fonr | input | 1 | Fault-on-read bit |
| tlb_fonw | input | 1 | Fault-on-write bit |
| va_rd | input | 1 | Software read of the fault-address register |
| req_ready | output | 1 | Block is in ST_IDLE |
| resp_valid | output | 1 | Response present (ST_DONE) |
| resp_fault | output | 3 | Fault class 0..5 |
| resp_paddr | output | 64 | Physical address |
| resp_uncached | output | 1 | Uncacheable access |
| flt_va | output | 64 | Captured faulting address |
| flt_stat | output | 17 | Captured status word |
| flt_vform | output | 64 | Captured formatted address |
| flt_locked | output | 1 | Fault registers locked |

## Verification
The assertions check on every cycle the properties that do not depend on the request's content. These are the response rhythm, the lock behaviour (a lock may rise only with a reported non-machine-check fault, the registers hold while locked, and a read strobe clears the lock), the rule that an uncacheable flag never comes with a fault, and the rule that a captured miss flag comes with a miss class. Only the bench's scenarios can show the request-dependent results. These are which flag set and class each path produces, the exact physical address including superpage sign extension, effective-mode selection, and the packed status and formatted address values. They are compared against a reference model over directed corner cases and seeded random traffic.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_ACV       = 3'd1,
        FLT_GENERIC   = 3'd2,
        FLT_MISS_PRI  = 3'd3,
        FLT_MISS_NEST = 3'd4,
        FLT_MCHK      = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    localparam int FLAG_W    = 6;
    localparam int FLG_WR    = 0;
    localparam int FLG_ACV   = 1;
    localparam int FLG_FONR  = 2;
    localparam int FLG_FONW  = 3;
    localparam int FLG_MISS  = 4;
    localparam int FLG_BADVA = 5;

    localparam int OPC_W  = 6;
    localparam int RA_W   = 5;
    localparam int STAT_W = OPC_W + RA_W + FLAG_W;
    localparam int NMODES = 4;

    typedef struct packed {
        logic is_write;
        logic physical;
        logic alt_req;
        logic pt_walk;
        logic pc_priv;
    } req_attr_t;

endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel
    import dtx_pkg::*;
(
    input  logic  pc_priv,
    input  logic  alt_req,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);

    always_comb begin
        if (pc_priv) begin
            eff_mode = alt_req ? alt_mode : MODE_KERNEL;
        end else begin
            eff_mode = cur_mode;
        end
    end

endmodule

// File: rtl/dtx_check.sv
module dtx_check
    import dtx_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int VA_BITS   = 43,
    parameter int PA_BITS   = 44,
    parameter int PAGE_BITS = 13,
    parameter int UC_LO     = 39,
    parameter int UC_HI     = 40,
    localparam int PFN_W    = PA_BITS - PAGE_BITS
) (
    input  req_attr_t          attr,
    input  mode_e              eff_mode,
    input  mode_e              cur_mode,
    input  logic               sp_en,
    input  logic [ADDR_W-1:0]  vaddr,
    input  logic               tlb_hit,
    input  logic [PFN_W-1:0]   tlb_pfn,
    input  logic [NMODES-1:0]  tlb_rd_en,
    input  logic [NMODES-1:0]  tlb_wr_en,
    input  logic               tlb_fonr,
    input  logic               tlb_fonw,
    output fault_e             fault,
    output logic [FLAG_W-1:0]  flags,
    output logic [ADDR_W-1:0]  paddr,
    output logic               uncached,
    output logic               capture
);

    localparam logic [ADDR_W-1:0] ONE       = 1;
    localparam logic [ADDR_W-1:0] IMPL_MASK = (ONE << PA_BITS) - ONE;
    localparam logic [ADDR_W-1:0] LOW_MASK  = (ONE << UC_HI) - ONE;
    localparam logic [ADDR_W-1:0] EXT_MASK  = IMPL_MASK & ~LOW_MASK;
    localparam int SIGN_LO = VA_BITS - 1;

    logic              va_ok;
    logic              in_spage;
    logic [ADDR_W-1:0] sp_raw;
    logic [ADDR_W-1:0] sp_pa;
    logic [ADDR_W-1:0] tlb_pa;
    logic              wr_ok;
    logic              rd_ok;
    fault_e            base_fault;
    logic [ADDR_W-1:0] base_pa;

    assign va_ok    = (&vaddr[ADDR_W-1:SIGN_LO]) | ~(|vaddr[ADDR_W-1:SIGN_LO]);
    assign in_spage = sp_en && (vaddr[VA_BITS-1:VA_BITS-2] == 2'b10);
    assign sp_raw   = vaddr & IMPL_MASK;
    assign sp_pa    = (sp_raw[UC_LO] | sp_raw[UC_HI]) ? (sp_raw | EXT_MASK)
                                                      : (sp_raw & LOW_MASK);
    assign tlb_pa   = {{(ADDR_W-PA_BITS){1'b0}}, tlb_pfn, vaddr[PAGE_BITS-1:0]};
    assign wr_ok    = tlb_wr_en[eff_mode];
    assign rd_ok    = tlb_rd_en[eff_mode];

    // Path selection and flag generation
    always_comb begin
        base_fault = FLT_NONE;
        flags      = '0;
        base_pa    = '0;
        if (attr.physical) begin
            base_pa = vaddr;
        end else if (!va_ok) begin
            base_fault        = FLT_GENERIC;
            flags[FLG_WR]     = attr.is_write;
            flags[FLG_BADVA]  = 1'b1;
            flags[FLG_ACV]    = 1'b1;
        end else if (in_spage) begin
            if (cur_mode != MODE_KERNEL) begin
                base_fault     = FLT_ACV;
                flags[FLG_WR]  = attr.is_write;
                flags[FLG_ACV] = 1'b1;
            end else begin
                base_pa = sp_pa;
            end
        end else if (!tlb_hit) begin
            base_fault      = attr.pt_walk ? FLT_MISS_PRI : FLT_MISS_NEST;
            flags[FLG_WR]   = attr.is_write;
            flags[FLG_MISS] = 1'b1;
        end else begin
            base_pa = tlb_pa;
            if (attr.is_write) begin
                if (!wr_ok) begin
                    base_fault      = FLT_GENERIC;
                    flags[FLG_WR]   = 1'b1;
                    flags[FLG_ACV]  = 1'b1;
                    flags[FLG_FONW] = tlb_fonw;
                end else if (tlb_fonw) begin
                    base_fault      = FLT_GENERIC;
                    flags[FLG_WR]   = 1'b1;
                    flags[FLG_FONW] = 1'b1;
                end
            end else begin
                if (!rd_ok) begin
                    base_fault      = FLT_ACV;
                    flags[FLG_ACV]  = 1'b1;
                    flags[FLG_FONR] = tlb_fonr;
                end else if (tlb_fonr) begin
                    base_fault      = FLT_GENERIC;
                    flags[FLG_FONR] = 1'b1;
                end
            end
        end
    end

    // Physical range check and cacheability
    always_comb begin
        paddr   = base_pa;
        capture = (base_fault != FLT_NONE);
        if ((base_fault == FLT_NONE) && (|(base_pa & ~IMPL_MASK))) begin
            fault = FLT_MCHK;
        end else begin
            fault = base_fault;
        end
        uncached = (fault == FLT_NONE) && (base_pa[UC_LO] | base_pa[UC_HI]);
    end

endmodule

// File: rtl/dtx_fault_regs.sv
module dtx_fault_regs
    import dtx_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    localparam int VPN_W    = VA_BITS - PAGE_BITS,
    localparam int VF_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              va_rd,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [RA_W-1:0]   ra,
    input  logic [FLAG_W-1:0] flags,
    input  logic [ADDR_W-1:0] vf_base,
    output logic [ADDR_W-1:0] flt_va,
    output logic [STAT_W-1:0] flt_stat,
    output logic [ADDR_W-1:0] flt_vform,
    output logic              locked
);

    logic [VPN_W-1:0]  vpn;
    logic [ADDR_W-1:0] vpn_fmt;

    assign vpn     = vaddr[VA_BITS-1:PAGE_BITS];
    assign vpn_fmt = {{(ADDR_W-VPN_W-VF_SHIFT){1'b0}}, vpn, {VF_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_va    <= '0;
            flt_stat  <= '0;
            flt_vform <= '0;
            locked    <= 1'b0;
        end else if (cap_en && !locked) begin
            flt_va    <= vaddr;
            flt_stat  <= {opcode, ra, flags};
            flt_vform <= vf_base | vpn_fmt;
            locked    <= 1'b1;
        end else if (va_rd) begin
            locked    <= 1'b0;
        end
    end

endmodule

// File: rtl/data_xlate_unit.sv
module data_xlate_unit
    import dtx_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int VA_BITS   = 43,
    parameter int PA_BITS   = 44,
    parameter int PAGE_BITS = 13,
    parameter int UC_LO     = 39,
    parameter int UC_HI     = 40,
    localparam int PFN_W    = PA_BITS - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_physical,
    input  logic              req_altmode,
    input  logic              req_ptwalk,
    input  logic              req_pc_priv,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [5:0]        req_opcode,
    input  logic [4:0]        req_ra,
    input  logic [1:0]        cfg_cur_mode,
    input  logic [1:0]        cfg_alt_mode,
    input  logic              cfg_spage_en,
    input  logic [ADDR_W-1:0] cfg_vform_base,
    input  logic              tlb_hit,
    input  logic [PFN_W-1:0]  tlb_pfn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fonr,
    input  logic              tlb_fonw,
    input  logic              va_rd,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [2:0]        resp_fault,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_uncached,
    output logic [ADDR_W-1:0] flt_va,
    output logic [16:0]       flt_stat,
    output logic [ADDR_W-1:0] flt_vform,
    output logic              flt_locked
);

    state_e state_q;
    state_e state_d;

    // Request snapshot
    req_attr_t         attr_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [OPC_W-1:0]  opc_q;
    logic [RA_W-1:0]   ra_q;
    mode_e             cur_q;
    mode_e             alt_q;
    logic              sp_en_q;
    logic [ADDR_W-1:0] base_q;
    logic              hit_q;
    logic [PFN_W-1:0]  pfn_q;
    logic [NMODES-1:0] rd_en_q;
    logic [NMODES-1:0] wr_en_q;
    logic              fonr_q;
    logic              fonw_q;

    // Evaluation results
    mode_e             eff_mode;
    fault_e            chk_fault;
    logic [FLAG_W-1:0] chk_flags;
    logic [ADDR_W-1:0] chk_paddr;
    logic              chk_unc;
    logic              chk_cap;
    fault_e            res_fault_q;
    logic [ADDR_W-1:0] res_paddr_q;
    logic              res_unc_q;
    logic              accept;
    logic              cap_en;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign cap_en = (state_q == ST_EVAL) && chk_cap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ACCEPT, EVALUATE, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        resp_valid    = (state_q == ST_DONE);
        resp_fault    = res_fault_q;
        resp_paddr    = res_paddr_q;
        resp_uncached = res_unc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q  <= '0;
            vaddr_q <= '0;
            opc_q   <= '0;
            ra_q    <= '0;
            cur_q   <= MODE_KERNEL;
            alt_q   <= MODE_KERNEL;
            sp_en_q <= 1'b0;
            base_q  <= '0;
            hit_q   <= 1'b0;
            pfn_q   <= '0;
            rd_en_q <= '0;
            wr_en_q <= '0;
            fonr_q  <= 1'b0;
            fonw_q  <= 1'b0;
        end else if (accept) begin
            attr_q  <= '{is_write: req_write, physical: req_physical,
                         alt_req: req_altmode, pt_walk: req_ptwalk,
                         pc_priv: req_pc_priv};
            vaddr_q <= req_vaddr;
            opc_q   <= req_opcode;
            ra_q    <= req_ra;
            cur_q   <= mode_e'(cfg_cur_mode);
            alt_q   <= mode_e'(cfg_alt_mode);
            sp_en_q <= cfg_spage_en;
            base_q  <= cfg_vform_base;
            hit_q   <= tlb_hit;
            pfn_q   <= tlb_pfn;
            rd_en_q <= tlb_rd_en;
            wr_en_q <= tlb_wr_en;
            fonr_q  <= tlb_fonr;
            fonw_q  <= tlb_fonw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_fault_q <= FLT_NONE;
            res_paddr_q <= '0;
            res_unc_q   <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            res_fault_q <= chk_fault;
            res_paddr_q <= chk_paddr;
            res_unc_q   <= chk_unc;
        end
    end

    dtx_mode_sel u_mode (
        .pc_priv  (attr_q.pc_priv),
        .alt_req  (attr_q.alt_req),
        .cur_mode (cur_q),
        .alt_mode (alt_q),
        .eff_mode (eff_mode)
    );

    dtx_check #(
        .ADDR_W    (ADDR_W),
        .VA_BITS   (VA_BITS),
        .PA_BITS   (PA_BITS),
        .PAGE_BITS (PAGE_BITS),
        .UC_LO     (UC_LO),
        .UC_HI     (UC_HI)
    ) u_check (
        .attr      (attr_q),
        .eff_mode  (eff_mode),
        .cur_mode  (cur_q),
        .sp_en     (sp_en_q),
        .vaddr     (vaddr_q),
        .tlb_hit   (hit_q),
        .tlb_pfn   (pfn_q),
        .tlb_rd_en (rd_en_q),
        .tlb_wr_en (wr_en_q),
        .tlb_fonr  (fonr_q),
        .tlb_fonw  (fonw_q),
        .fault     (chk_fault),
        .flags     (chk_flags),
        .paddr     (chk_paddr),
        .uncached  (chk_unc),
        .capture   (chk_cap)
    );

    dtx_fault_regs #(
        .ADDR_W    (ADDR_W),
        .VA_BITS   (VA_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_fregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .va_rd     (va_rd),
        .vaddr     (vaddr_q),
        .opcode    (opc_q),
        .ra        (ra_q),
        .flags     (chk_flags),
        .vf_base   (base_q),
        .flt_va    (flt_va),
        .flt_stat  (flt_stat),
        .flt_vform (flt_vform),
        .locked    (flt_locked)
    );

endmodule

// File: rtl/data_xlate_unit_chk.sv
module data_xlate_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic [2:0]  resp_fault,
    input logic        resp_uncached,
    input logic        va_rd,
    input logic [63:0] flt_va,
    input logic [16:0] flt_stat,
    input logic [63:0] flt_vform,
    input logic        flt_locked
);

    p_resp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_accept_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!req_ready && !resp_valid) ##1 resp_valid);

    p_lock_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_locked && !va_rd) |=> (flt_locked && $stable(flt_va)
                                    && $stable(flt_stat) && $stable(flt_vform)));

    p_unlock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_locked && va_rd) |=> !flt_locked);

    p_capture_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_locked) |-> (resp_valid && resp_fault != 3'd0 && resp_fault != 3'd5));

    p_mchk_nocap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 3'd5) |-> !$rose(flt_locked));

    p_unc_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 3'd0) |-> !resp_uncached);

    p_miss_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flt_locked) && flt_stat[4]) |-> (resp_fault == 3'd3 || resp_fault == 3'd4));

endmodule

bind data_xlate_unit data_xlate_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .resp_uncached (resp_uncached),
    .va_rd         (va_rd),
    .flt_va        (flt_va),
    .flt_stat      (flt_stat),
    .flt_vform     (flt_vform),
    .flt_locked    (flt_locked)
);

// File: tb/data_xlate_unit_tb_top.sv
module data_xlate_unit_tb_top;

    localparam logic [2:0] F_NONE = 3'd0, F_ACV = 3'd1, F_GEN = 3'd2,
                           F_MPRI = 3'd3, F_MNEST = 3'd4, F_MCHK = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_physical = 0, req_altmode = 0;
    logic        req_ptwalk = 0, req_pc_priv = 0;
    logic [63:0] req_vaddr = '0;
    logic [5:0]  req_opcode = '0;
    logic [4:0]  req_ra = '0;
    logic [1:0]  cfg_cur_mode = '0, cfg_alt_mode = '0;
    logic        cfg_spage_en = 0;
    logic [63:0] cfg_vform_base = '0;
    logic        tlb_hit = 0;
    logic [30:0] tlb_pfn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fonr = 0, tlb_fonw = 0;
    logic        va_rd = 0;
    logic        req_ready, resp_valid, resp_uncached, flt_locked;
    logic [2:0]  resp_fault;
    logic [63:0] resp_paddr, flt_va, flt_vform;
    logic [16:0] flt_stat;

    int total = 0;
    int bad = 0;

    // Lock-state model
    logic        m_lock = 0;
    logic [63:0] m_va = '0, m_vf = '0;
    logic [16:0] m_stat = '0;

    always #10 clk = ~clk;

    data_xlate_unit dut_i (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(output logic [2:0] f, output logic [5:0] fl,
                                  output logic [63:0] pa, output logic uc);
        logic [1:0]  m;
        logic [63:0] sp;
        logic [21:0] top;
        f = F_NONE; fl = '0; pa = '0;
        m = req_pc_priv ? (req_altmode ? cfg_alt_mode : 2'd0) : cfg_cur_mode;
        top = req_vaddr[63:42];
        if (req_physical) begin
            pa = req_vaddr;
        end else if (!(top == '0 || top == '1)) begin
            f = F_GEN; fl = {1'b1, 3'b000, 1'b1, req_write};
        end else if (cfg_spage_en && req_vaddr[42:41] == 2'b10) begin
            if (cfg_cur_mode != 2'd0) begin
                f = F_ACV; fl = {4'b0000, 1'b1, req_write};
            end else begin
                sp = req_vaddr & 64'h0000_0FFF_FFFF_FFFF;
                if (sp[39] || sp[40]) pa = sp | 64'h0000_0F00_0000_0000;
                else pa = sp & 64'h0000_00FF_FFFF_FFFF;
            end
        end else if (!tlb_hit) begin
            f = req_ptwalk ? F_MPRI : F_MNEST;
            fl = {2'b01, 3'b000, req_write};
        end else begin
            pa = {20'd0, tlb_pfn, req_vaddr[12:0]};
            if (req_write) begin
                if (!tlb_wr_en[m]) begin f = F_GEN; fl = {2'b00, tlb_fonw, 3'b011}; end
                else if (tlb_fonw) begin f = F_GEN; fl = 6'b001001; end
            end else begin
                if (!tlb_rd_en[m]) begin f = F_ACV; fl = {3'b000, tlb_fonr, 2'b10}; end
                else if (tlb_fonr) begin f = F_GEN; fl = 6'b000100; end
            end
        end
        if (f == F_NONE && pa[63:44] != 0) f = F_MCHK;
        uc = (f == F_NONE) && (pa[39] || pa[40]);
    endfunction

    // One transaction: drive, wait for the response, compare.
    task automatic xact(string tag);
        logic [2:0]  ef;
        logic [5:0]  efl;
        logic [63:0] epa;
        logic        euc;
        int          waited;
        model(ef, efl, epa, euc);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!resp_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R13 latency"}, 64'(waited), 64'd1);
        chk({tag, " fault"}, 64'(resp_fault), 64'(ef));
        if (ef == F_NONE) chk({tag, " R8 paddr"}, resp_paddr, epa);
        chk({tag, " R10 uncached"}, 64'(resp_uncached), 64'(euc));
        if (ef != F_NONE && ef != F_MCHK && !m_lock) begin
            m_lock = 1'b1;
            m_va   = req_vaddr;
            m_stat = {req_opcode, req_ra, efl};
            m_vf   = cfg_vform_base | {31'd0, req_vaddr[42:13], 3'b000};
        end
        chk({tag, " R12 locked"}, 64'(flt_locked), 64'(m_lock));
        chk({tag, " R11 fault va"}, flt_va, m_va);
        chk({tag, " R11 status"}, 64'(flt_stat), 64'(m_stat));
        chk({tag, " R11 vform"}, flt_vform, m_vf);
    endtask

    task automatic read_va(string tag);
        @(negedge clk);
        va_rd = 1'b1;
        @(negedge clk);
        va_rd = 1'b0;
        m_lock = 1'b0;
        chk({tag, " R12 unlock"}, 64'(flt_locked), 64'd0);
    endtask

    task automatic set_tlb(logic hit, logic [3:0] rd, logic [3:0] wr, logic fr, logic fw);
        tlb_hit = hit; tlb_rd_en = rd; tlb_wr_en = wr; tlb_fonr = fr; tlb_fonw = fw;
    endtask

    task automatic rand_req();
        logic [63:0] r;
        int          kind;
        r = {$urandom, $urandom};
        kind = $urandom % 8;
        req_vaddr = {{21{r[42]}}, r[42:0]};
        if (kind == 2) req_vaddr = {{21{1'b1}}, 2'b10, r[40:0]};
        if (kind == 0) req_vaddr[50] = ~req_vaddr[50];
        req_physical = (kind == 1);
        if (kind == 1 && $urandom % 2 == 1) req_vaddr = r;
        req_write = 1'($urandom); req_altmode = 1'($urandom);
        req_ptwalk = 1'($urandom); req_pc_priv = 1'($urandom);
        req_opcode = 6'($urandom); req_ra = 5'($urandom);
        cfg_cur_mode = 2'($urandom); cfg_alt_mode = 2'($urandom);
        cfg_spage_en = ($urandom % 4 != 0);
        cfg_vform_base = {$urandom, $urandom} & 64'hFFFF_FFF0_0000_0000;
        tlb_hit = ($urandom % 4 != 0);
        tlb_pfn = 31'($urandom);
        tlb_rd_en = 4'($urandom); tlb_wr_en = 4'($urandom);
        tlb_fonr = ($urandom % 4 == 0); tlb_fonw = ($urandom % 4 == 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset R13 ready", 64'(req_ready), 64'd1);
        chk("reset R13 resp_valid", 64'(resp_valid), 64'd0);
        chk("reset R12 locked", 64'(flt_locked), 64'd0);
        chk("reset R11 fault va", flt_va, 64'd0);

        // R1: alternate mode in privileged code (user only may read)
        req_vaddr = 64'h0000_0000_1234_5678; tlb_pfn = 31'h1234;
        set_tlb(1, 4'b1000, 4'b0000, 0, 0);
        req_pc_priv = 1; req_altmode = 1; cfg_alt_mode = 2'd3; cfg_cur_mode = 2'd0;
        xact("R1 alt mode read ok");
        // R1: privileged without alternate flag -> kernel, user-only enable fails
        req_altmode = 0; cfg_cur_mode = 2'd3;
        xact("R1 kernel override acv");
        read_va("R1");
        // R1: outside privileged code current mode applies
        req_pc_priv = 0; cfg_cur_mode = 2'd2; set_tlb(1, 4'b0100, 4'b0000, 0, 0);
        xact("R1 current mode ok");

        // R2 / R9 / R10: physical paths
        req_physical = 1; req_vaddr = 64'h0000_0100_0000_2000;
        xact("R2 R10 phys uncached");
        req_vaddr = 64'h0004_0000_0000_0040;
        xact("R9 phys mchk");
        chk("R9 no capture", 64'(flt_locked), 64'd0);
        req_physical = 0;

        // R3: invalid address, store
        req_write = 1; req_vaddr = 64'h0100_0000_0000_0000;
        req_opcode = 6'h2d; req_ra = 5'h13;
        xact("R3 bad va");
        chk("R3 R11 status exact", 64'(flt_stat), 64'((6'h2d << 11) | (5'h13 << 6) | 6'b100011));
        // R12: a second fault while locked does not disturb
        req_vaddr = 64'h0000_0000_0000_4000; set_tlb(0, 0, 0, 0, 0);
        xact("R12 locked hold");
        read_va("R12");

        // R4: superpage
        cfg_spage_en = 1; req_write = 0; cfg_cur_mode = 2'd1;
        req_vaddr = 64'hFFFF_FC80_0000_1000;
        xact("R4 superpage non-kernel");
        read_va("R4");
        cfg_cur_mode = 2'd0;
        xact("R4 R10 superpage ext");
        chk("R4 sign extended", resp_paddr, 64'h0000_0F80_0000_1000);
        req_vaddr = 64'hFFFF_FC20_0000_1000;
        xact("R4 superpage clear");
        chk("R4 cleared", resp_paddr, 64'h0000_0020_0000_1000);
        cfg_spage_en = 0;

        // R5: misses
        req_vaddr = 64'h0000_0000_0ABC_D000; set_tlb(0, 0, 0, 0, 0);
        req_ptwalk = 1; req_write = 1;
        xact("R5 primary miss");
        read_va("R5");
        req_ptwalk = 0;
        xact("R5 nested miss");
        read_va("R5b");

        // R6: stores
        cfg_cur_mode = 2'd0; set_tlb(1, 4'b1111, 4'b1110, 0, 1);
        xact("R6 store no perm fonw");
        chk("R6 flags", 64'(flt_stat[5:0]), 64'b001011);
        read_va("R6");
        set_tlb(1, 4'b1111, 4'b0001, 0, 1);
        xact("R6 store fonw");
        chk("R6 flags b", 64'(flt_stat[5:0]), 64'b001001);
        read_va("R6b");

        // R7: loads
        req_write = 0; set_tlb(1, 4'b1110, 4'b1111, 1, 0);
        xact("R7 load no perm fonr");
        chk("R7 flags", 64'(flt_stat[5:0]), 64'b000110);
        read_va("R7");
        set_tlb(1, 4'b0001, 4'b0000, 1, 0);
        xact("R7 load fonr");
        chk("R7 flags b", 64'(flt_stat[5:0]), 64'b000100);
        read_va("R7b");

        // R13: request held high while busy is ignored
        set_tlb(1, 4'b1111, 4'b1111, 0, 0); tlb_pfn = 31'h55;
        req_vaddr = 64'h0000_0000_0000_0123;
        @(negedge clk); req_valid = 1;
        @(negedge clk); req_vaddr = 64'h0000_0000_0000_1FFF;
        @(negedge clk);
        chk("R13 resp", 64'(resp_valid), 64'd1);
        chk("R13 first req kept", resp_paddr, {20'd0, 31'h55, 13'h0123});
        req_valid = 0;
        @(negedge clk);
        chk("R13 back idle", 64'(req_ready), 64'd1);

        // Seeded random traffic (R8 covers the main translation)
        for (int i = 0; i < 400; i++) begin
            rand_req();
            if ($urandom % 3 == 0) read_va("random R12");
            xact("random R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule